// File: doc/BRIEF.md
# Per-Region Bounded Error Logger

This block captures failures reported by a memory test engine into a small on-chip table. Each failure arrives as one valid cycle carrying the failing word address, the data that was written and the data that was read back. The address space is split into 4K-word regions. Each region from the third one upward owns a fixed group of table entries, so a badly broken region cannot crowd the others out of the log.

A failure at an address that a region has already logged only raises that entry's occurrence count. A new address takes the lowest free entry of its region. Once a region's entries are all taken, further new addresses in it are dropped. Logging happens only while an enable input is high. A synchronous clear empties the table. A host reads the table one word at a time through a combinational port and also sees the number of allocated entries and a running total of accepted failures.

Top module: `region_err_logger`

## Requirements
- R1: After reset, and in the cycle after `clr_table` is high, every table word reads 0 and `used_entries` and `err_total` are 0. A clear takes priority over a failure presented in the same cycle.
- R2: A new failing address in region r (r = `err_addr[14:12]`, valid for r = 2..7) fills entry e = (r-2)*4 + slot. Words 5e, 5e+1, 5e+2, 5e+3 and 5e+4 then read the address, the written data, the read data, 0 and a count of 1.
- R3: A failure at an address already logged in its region raises that entry's count by one. It does not allocate an entry and does not change the stored written or read data.
- R4: The occurrence count saturates at 2^CNT_W-1 and never wraps.
- R5: When all four entries of a region are taken, a failure at a new address in that region leaves the table unchanged.
- R6: Failures at addresses below 8K (regions 0 and 1) change neither the table nor `err_total`.
- R7: While `log_en` is low, failures change neither the table nor `err_total`.
- R8: `err_total` increments once for every failure in regions 2..7 while logging is enabled. This includes repeats and failures dropped under R5. It saturates at 2^TOT_W-1.
- R9: `used_entries` equals the number of allocated entries.
- R10: Read addresses at or beyond the end of the table (word 120 and up with default parameters) return 0.
- R11: Within a region, entries are taken lowest slot first. Filling one region has no effect on the entries of any other region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_table | input | 1 | Synchronous clear of all entries and counts |
| log_en | input | 1 | Logging enable |
| err_valid | input | 1 | A failure is presented this cycle |
| err_addr | input | ADDR_W | Failing word address |
| err_good | input | DATA_W | Data written |
| err_bad | input | DATA_W | Data read back |
| rd_addr | input | RD_W | Table word address |
| rd_data | output | DATA_W | Table word, combinational |
| used_entries | output | USED_W | Number of allocated entries |
| err_total | output | TOT_W | Saturating count of accepted failures |

## Verification
The bench builds the logger with a 3-bit occurrence count and a 6-bit total, and keeps every other parameter at its default. This puts count saturation within eight hits on one address and total saturation within 63 accepted failures. Both limits are therefore reached in a few hundred cycles, next to region overflow, an out-of-window read and a clear that collides with a failure.

// File: rtl/elog_pkg.sv
// Package: shared constants and the word layout of one table entry.
// Assumes: an entry is read as five consecutive words in the order below.
package elog_pkg;
    localparam int unsigned ENTRY_WORDS = 5;

    typedef enum logic [2:0] {
        WD_ADDR  = 3'd0,
        WD_GOOD  = 3'd1,
        WD_BAD   = 3'd2,
        WD_RSVD  = 3'd3,
        WD_COUNT = 3'd4
    } word_sel_e;
endpackage

// File: rtl/elog_intake.sv
// Module: elog_intake
// Filters incoming failures by enable and by region, steers an accepted
// failure to the bank of its region, and keeps the saturating total.
// Assumes: regions below FIRST_REGION or beyond the last bank are not logged.
module elog_intake #(
    parameter int ADDR_W       = 15,
    parameter int REGION_W     = 12,
    parameter int FIRST_REGION = 2,
    parameter int NUM_REGIONS  = 6,
    parameter int TOT_W        = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   err_valid,
    input  logic                   log_en,
    input  logic [ADDR_W-1:0]      err_addr,
    output logic [NUM_REGIONS-1:0] bank_hit,
    output logic [TOT_W-1:0]       total
);
    localparam int RSEL_W = ADDR_W - REGION_W;

    logic [RSEL_W-1:0] region;
    logic              in_window;
    logic              accept;

    // Region number and window test for the presented address.
    always_comb begin
        region    = err_addr[ADDR_W-1:REGION_W];
        in_window = (int'(region) >= FIRST_REGION) &&
                    (int'(region) <  FIRST_REGION + NUM_REGIONS);
        accept    = err_valid && log_en && in_window;
    end

    // One hit line per region bank.
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_hit
        assign bank_hit[g] = accept && (int'(region) == FIRST_REGION + g);
    end

    // Saturating count of accepted failures.
    always_ff @(posedge clk) begin
        if (!rst_n)                     total <= '0;
        else if (clr)                   total <= '0;
        else if (accept && total != '1) total <= total + 1'b1;
    end

    p_ignore_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && int'(region) < FIRST_REGION && !clr) |=> $stable(total));

    p_ignore_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && !log_en && !clr) |=> $stable(total));

    p_total_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (total == '1 && !clr) |=> total == '1);
endmodule

// File: rtl/elog_region.sv
// Module: elog_region
// Holds the entries of one region. A hit whose address matches a stored
// entry bumps that entry's count; otherwise the lowest free slot is filled;
// with no free slot the hit is dropped.
// Assumes: at most one hit per cycle; clear overrides a hit.
module elog_region #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 16,
    parameter int SLOTS  = 4,
    parameter int CNT_W  = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              clr,
    input  logic                              hit,
    input  logic [ADDR_W-1:0]                 fa,
    input  logic [DATA_W-1:0]                 fg,
    input  logic [DATA_W-1:0]                 fb,
    output logic [SLOTS-1:0]                  slot_vld,
    output logic [SLOTS-1:0][ADDR_W-1:0]      slot_addr,
    output logic [SLOTS-1:0][DATA_W-1:0]      slot_good,
    output logic [SLOTS-1:0][DATA_W-1:0]      slot_bad,
    output logic [SLOTS-1:0][CNT_W-1:0]       slot_cnt
);
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [SLOTS-1:0] match;
    logic             any_match;
    logic             have_free;
    logic [IDX_W-1:0] free_idx;

    // Address match against every stored entry.
    always_comb begin
        for (int i = 0; i < SLOTS; i++)
            match[i] = slot_vld[i] && (slot_addr[i] == fa);
        any_match = |match;
    end

    // Lowest free slot.
    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!slot_vld[i]) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
        end
    end

    // Entry storage: clear, bump a matching count, or allocate.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            slot_vld  <= '0;
            slot_addr <= '0;
            slot_good <= '0;
            slot_bad  <= '0;
            slot_cnt  <= '0;
        end else if (hit) begin
            if (any_match) begin
                for (int i = 0; i < SLOTS; i++)
                    if (match[i] && slot_cnt[i] != CNT_MAX)
                        slot_cnt[i] <= slot_cnt[i] + 1'b1;
            end else if (have_free) begin
                slot_vld[free_idx]  <= 1'b1;
                slot_addr[free_idx] <= fa;
                slot_good[free_idx] <= fg;
                slot_bad[free_idx]  <= fb;
                slot_cnt[free_idx]  <= CNT_W'(1);
            end
        end
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_chk
        p_cnt_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr && slot_vld[s] && slot_cnt[s] == CNT_MAX) |=> slot_cnt[s] == CNT_MAX);

        p_entry_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr && slot_vld[s]) |=> (slot_vld[s] && $stable(slot_addr[s]) &&
                                       $stable(slot_good[s]) && $stable(slot_bad[s])));
    end

    p_full_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !clr && (&slot_vld) && !any_match) |=> $stable(slot_cnt));

    p_one_alloc_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ($countones(slot_vld) <= $past($countones(slot_vld)) + 1));
endmodule

// File: rtl/elog_readout.sv
// Module: elog_readout
// Combinational word-addressed view of the whole table, five words per
// entry. Unallocated entries, the reserved word and addresses past the
// table read as zero.
// Assumes: ADDR_W and CNT_W are not wider than DATA_W.
module elog_readout
    import elog_pkg::*;
#(
    parameter int ADDR_W  = 15,
    parameter int DATA_W  = 16,
    parameter int CNT_W   = 16,
    parameter int ENTRIES = 24,
    parameter int RD_W    = 7
) (
    input  logic [RD_W-1:0]                 rd_addr,
    input  logic [ENTRIES-1:0]              e_vld,
    input  logic [ENTRIES-1:0][ADDR_W-1:0]  e_addr,
    input  logic [ENTRIES-1:0][DATA_W-1:0]  e_good,
    input  logic [ENTRIES-1:0][DATA_W-1:0]  e_bad,
    input  logic [ENTRIES-1:0][CNT_W-1:0]   e_cnt,
    output logic [DATA_W-1:0]               rd_data
);
    localparam int WORDS = ENTRIES * ENTRY_WORDS;

    // Split the word address into entry and word and select the field.
    always_comb begin
        int unsigned e;
        int unsigned w;
        rd_data = '0;
        e = int'(rd_addr) / ENTRY_WORDS;
        w = int'(rd_addr) % ENTRY_WORDS;
        if (int'(rd_addr) < WORDS && e < ENTRIES) begin
            if (e_vld[e]) begin
                case (word_sel_e'(w[2:0]))
                    WD_ADDR:  rd_data = DATA_W'(e_addr[e]);
                    WD_GOOD:  rd_data = e_good[e];
                    WD_BAD:   rd_data = e_bad[e];
                    WD_COUNT: rd_data = DATA_W'(e_cnt[e]);
                    default:  rd_data = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/region_err_logger.sv
// Module: region_err_logger (top)
// Logs memory test failures into per-region groups of entries, merges
// repeats into an occurrence count and exposes the table for reading.
// Assumes: one failure per cycle at most; synchronous active-low reset.
module region_err_logger #(
    parameter  int ADDR_W       = 15,
    parameter  int DATA_W       = 16,
    parameter  int REGION_W     = 12,
    parameter  int FIRST_REGION = 2,
    parameter  int SLOTS        = 4,
    parameter  int CNT_W        = 16,
    parameter  int TOT_W        = 16,
    localparam int NUM_REGIONS  = (1 << (ADDR_W - REGION_W)) - FIRST_REGION,
    localparam int ENTRIES      = NUM_REGIONS * SLOTS,
    localparam int WORDS        = ENTRIES * 5,
    localparam int RD_W         = $clog2(WORDS),
    localparam int USED_W       = $clog2(ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_table,
    input  logic              log_en,
    input  logic              err_valid,
    input  logic [ADDR_W-1:0] err_addr,
    input  logic [DATA_W-1:0] err_good,
    input  logic [DATA_W-1:0] err_bad,
    input  logic [RD_W-1:0]   rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [USED_W-1:0] used_entries,
    output logic [TOT_W-1:0]  err_total
);
    logic [NUM_REGIONS-1:0]            bank_hit;
    logic [ENTRIES-1:0]                all_vld;
    logic [ENTRIES-1:0][ADDR_W-1:0]    all_addr;
    logic [ENTRIES-1:0][DATA_W-1:0]    all_good;
    logic [ENTRIES-1:0][DATA_W-1:0]    all_bad;
    logic [ENTRIES-1:0][CNT_W-1:0]     all_cnt;

    elog_intake #(
        .ADDR_W(ADDR_W), .REGION_W(REGION_W), .FIRST_REGION(FIRST_REGION),
        .NUM_REGIONS(NUM_REGIONS), .TOT_W(TOT_W)
    ) u_intake (
        .clk(clk), .rst_n(rst_n), .clr(clr_table), .err_valid(err_valid),
        .log_en(log_en), .err_addr(err_addr), .bank_hit(bank_hit), .total(err_total)
    );

    // One bank per loggable region.
    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_bank
        elog_region #(
            .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOTS(SLOTS), .CNT_W(CNT_W)
        ) u_bank (
            .clk(clk), .rst_n(rst_n), .clr(clr_table), .hit(bank_hit[r]),
            .fa(err_addr), .fg(err_good), .fb(err_bad),
            .slot_vld (all_vld [r*SLOTS +: SLOTS]),
            .slot_addr(all_addr[r*SLOTS +: SLOTS]),
            .slot_good(all_good[r*SLOTS +: SLOTS]),
            .slot_bad (all_bad [r*SLOTS +: SLOTS]),
            .slot_cnt (all_cnt [r*SLOTS +: SLOTS])
        );
    end

    elog_readout #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
        .ENTRIES(ENTRIES), .RD_W(RD_W)
    ) u_read (
        .rd_addr(rd_addr), .e_vld(all_vld), .e_addr(all_addr), .e_good(all_good),
        .e_bad(all_bad), .e_cnt(all_cnt), .rd_data(rd_data)
    );

    // Population count of allocated entries.
    always_comb begin
        used_entries = '0;
        for (int i = 0; i < ENTRIES; i++)
            used_entries += USED_W'(all_vld[i]);
    end

    p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clr_table |=> (used_entries == '0 && err_total == '0));

    p_used_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_table |=> (used_entries <= $past(used_entries) + 1'b1));
endmodule

// File: tb/region_err_logger_bench.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared every clock, plus directed
// checks tagged with the requirement they cover.
module region_err_logger_bench;
    localparam int CW = 3;
    localparam int TW = 6;
    localparam int CMAX = 7;
    localparam int TMAX = 63;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        clr_table = 0;
    logic        log_en = 0;
    logic        err_valid = 0;
    logic [14:0] err_addr = '0;
    logic [15:0] err_good = '0;
    logic [15:0] err_bad = '0;
    logic [6:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [4:0]  used_entries;
    logic [5:0]  err_total;

    region_err_logger #(.CNT_W(CW), .TOT_W(TW)) u_region_err_logger (
        .clk(clk), .rst_n(rst_n), .clr_table(clr_table), .log_en(log_en),
        .err_valid(err_valid), .err_addr(err_addr), .err_good(err_good),
        .err_bad(err_bad), .rd_addr(rd_addr), .rd_data(rd_data),
        .used_entries(used_entries), .err_total(err_total)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int scan  = 0;

    // Reference model state
    bit m_vld [24];
    int m_addr[24];
    int m_good[24];
    int m_bad [24];
    int m_cnt [24];
    int m_tot;

    function automatic void m_clear();
        for (int i = 0; i < 24; i++) begin
            m_vld[i] = 0; m_addr[i] = 0; m_good[i] = 0; m_bad[i] = 0; m_cnt[i] = 0;
        end
        m_tot = 0;
    endfunction

    function automatic void m_fail(bit en, int a, int g, int b);
        int rg;
        int base;
        rg = a >> 12;
        if (!en || rg < 2) return;
        if (m_tot < TMAX) m_tot++;
        base = (rg - 2) * 4;
        for (int i = base; i < base + 4; i++)
            if (m_vld[i] && m_addr[i] == a) begin
                if (m_cnt[i] < CMAX) m_cnt[i]++;
                return;
            end
        for (int i = base; i < base + 4; i++)
            if (!m_vld[i]) begin
                m_vld[i] = 1; m_addr[i] = a; m_good[i] = g; m_bad[i] = b; m_cnt[i] = 1;
                return;
            end
    endfunction

    function automatic int m_used();
        int n = 0;
        for (int i = 0; i < 24; i++) n += int'(m_vld[i]);
        return n;
    endfunction

    function automatic int exp_word(int i);
        int e;
        if (i >= 120) return 0;
        e = i / 5;
        if (!m_vld[e]) return 0;
        case (i % 5)
            0: return m_addr[e];
            1: return m_good[e];
            2: return m_bad[e];
            4: return m_cnt[e];
            default: return 0;
        endcase
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock: drive after the falling edge, compare at the next falling edge.
    task automatic cyc(bit v, bit en, bit c, int a, int g, int b);
        err_valid = v; log_en = en; clr_table = c;
        err_addr = 15'(a); err_good = 16'(g); err_bad = 16'(b);
        rd_addr = 7'(scan);
        if (c || !rst_n) m_clear();
        else if (v) m_fail(en, a, g, b);
        @(posedge clk);
        @(negedge clk);
        err_valid = 0; clr_table = 0;
        chk("R2 model word", int'(rd_data), exp_word(scan));
        chk("R9 model used", int'(used_entries), m_used());
        chk("R8 model total", int'(err_total), m_tot);
        scan = (scan + 1) % 128;
    endtask

    // Full table read while idle; compares every word to the model.
    task automatic sweep(string tag);
        for (int i = 0; i < 128; i++) begin
            rd_addr = 7'(i);
            #0.01;
            chk(tag, int'(rd_data), exp_word(i));
        end
        @(negedge clk);
    endtask

    task automatic peek(string tag, int adr, int exp);
        rd_addr = 7'(adr);
        #0.01;
        chk(tag, int'(rd_data), exp);
    endtask

    initial begin
        #(200000 * 5);
        n_err++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        m_clear();
        @(negedge clk);
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 0);
        rst_n = 1;
        cyc(0, 1, 0, 0, 0, 0);
        // R1: empty after reset
        sweep("R1 reset table");
        chk("R1 reset used", int'(used_entries), 0);
        chk("R1 reset total", int'(err_total), 0);

        // R2: first failure in region 2
        cyc(1, 1, 0, 'h2005, 'hA5A5, 'hA4A5);
        peek("R2 addr word", 0, 'h2005);
        peek("R2 good word", 1, 'hA5A5);
        peek("R2 bad word", 2, 'hA4A5);
        peek("R2 reserved word", 3, 0);
        peek("R2 count word", 4, 1);
        chk("R9 used one", int'(used_entries), 1);

        // R3: repeat keeps data, bumps count
        cyc(1, 1, 0, 'h2005, 'h1111, 'h2222);
        peek("R3 count two", 4, 2);
        peek("R3 good kept", 1, 'hA5A5);
        chk("R3 no new entry", int'(used_entries), 1);

        // R4: count saturates at 7
        for (int i = 0; i < 8; i++) cyc(1, 1, 0, 'h2005, 'h3333, 'h4444);
        peek("R4 count saturated", 4, CMAX);
        chk("R8 total ten", int'(err_total), 10);

        // R11: lowest free slot order
        cyc(1, 1, 0, 'h2100, 'h0001, 'h0000);
        cyc(1, 1, 0, 'h2200, 'h0002, 'h0000);
        cyc(1, 1, 0, 'h2FFE, 'h0003, 'h0000);
        peek("R11 slot1", 5, 'h2100);
        peek("R11 slot2", 10, 'h2200);
        peek("R11 slot3", 15, 'h2FFE);
        chk("R9 used four", int'(used_entries), 4);

        // R5: full region drops a new address
        cyc(1, 1, 0, 'h2FFF, 'hBEEF, 'hDEAD);
        sweep("R5 full region unchanged");
        chk("R5 used stays", int'(used_entries), 4);
        chk("R8 dropped still counted", int'(err_total), 14);

        // R11: other region unaffected by full region 2
        cyc(1, 1, 0, 'h7ABC, 'h5555, 'h5554);
        peek("R11 region7 entry", 100, 'h7ABC);
        peek("R11 region7 count", 104, 1);

        // R6: below 8K ignored
        cyc(1, 1, 0, 'h1FFF, 'h1234, 'h4321);
        cyc(1, 1, 0, 'h0003, 'h1234, 'h4321);
        chk("R6 total unchanged", int'(err_total), 15);
        chk("R6 used unchanged", int'(used_entries), 5);

        // R7: disabled logging ignored
        cyc(1, 0, 0, 'h3000, 'h1234, 'h4321);
        peek("R7 region3 empty", 20, 0);
        chk("R7 total unchanged", int'(err_total), 15);

        // R10: reads past the table
        for (int i = 120; i < 128; i++) peek("R10 out of window", i, 0);

        // R8: total saturates
        for (int i = 0; i < 60; i++) cyc(1, 1, 0, 'h7ABC, 0, 0);
        chk("R8 total saturated", int'(err_total), TMAX);
        sweep("R8 table after saturation");

        // R1: clear beats a concurrent failure
        cyc(1, 1, 1, 'h4000, 'h0F0F, 'h0F0E);
        sweep("R1 cleared table");
        chk("R1 clear used", int'(used_entries), 0);
        chk("R1 clear total", int'(err_total), 0);

        // R2: logging resumes in region 4 after clear
        cyc(1, 1, 0, 'h4000, 'h0F0F, 'h0F0E);
        peek("R2 region4 entry", 40, 'h4000);
        peek("R2 region4 bad", 42, 'h0F0E);

        for (int i = 0; i < 10; i++) cyc(0, 1, 0, 0, 0, 0);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule